// File: doc/BRIEF.md
# I2C Target Controller with Blocking Clock-Stretch Handshake

This block is the target (slave) side of a two-wire I2C bus. It samples the serial clock and data lines, waits for a start condition, shifts in a 7-bit address and the read/write bit, and compares the address with a programmable own address. Addresses that do not match are dropped without any notice to the host. Traffic seen before a start condition is ignored in the same way.

Each event that needs the host is a blocking handshake. These events are an accepted address and every data byte in either direction. The block raises a flag and holds the clock line low until the host writes a one to that flag's clear bit. When it clears the flag, the host chooses whether the address or received byte is acknowledged. For reads, the host supplies the byte to be sent at the moment it clears the data-ready flag.

A transmit collision occurs when the block lets the data line float high but finds it low. The block then lets go of both lines quietly and records the event in a status bit. The host finds that bit at the next address match. The bus pins are modelled as drive-low enables for open-drain pads.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset or after returning to idle, clocked bus bits are ignored until a start condition (data falling while clock is high) is seen: no flag is raised and neither line is driven.
- R2: A received address byte whose upper seven bits differ from `own_addr` raises no flag, is not acknowledged (data line released on the ninth clock), and the block ignores further bytes until the next start.
- R3: A start followed by an address byte whose upper seven bits equal `own_addr` sets `amatch_flag` after the falling clock edge of the eighth bit.
- R4: While `amatch_flag` is set, `scl_drive_low` stays asserted for as long as the host leaves the flag set. Releasing the master's clock does not free the bus.
- R5: `dir` takes bit 0 of the address byte (1 = master reads) only when an address matches, and keeps its value otherwise.
- R6: The acknowledge that follows an address or a received byte is the one selected by `nack_cmd` when the host clears the flag (0 = ACK, data line driven low; 1 = NACK, line released). After a NACK, bytes are ignored until the next start or stop.
- R7: In a master write, each received byte appears on `rx_data` (first bit received is bit 7). `drdy_flag` is set and the clock is held low before the acknowledge bit.
- R8: In a master read, an acknowledged address sets `drdy_flag` and holds the clock low. Clearing the flag loads `tx_data`, which is shifted out most significant bit first.
- R9: After each transmitted byte, a master ACK sets `drdy_flag` again and holds the clock. A master NACK ends the read with both lines released and no flag.
- R10: If the block releases the data line while sending a 1 but samples it low on the rising clock, it releases both lines, raises no flag and sets `coll`. `coll` stays set until the host clears the next `amatch_flag`.
- R11: A repeated start during a transfer returns the block to address reception, so a new matching address with a new direction is accepted.
- R12: A stop condition (data rising while clock is high) returns the block to idle. It sets `stop_flag` only when `stop_irq_en` is 1 and the block had been addressed.
- R13: All flags are zero after reset. `flag_clr` clears flags by writing ones: bit 0 clears `amatch_flag`, bit 1 clears `drdy_flag`, bit 2 clears `stop_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| scl_drive_low | output | 1 | Pull the clock line low (stretch) |
| sda_drive_low | output | 1 | Pull the data line low |
| own_addr | input | 7 | Programmed target address |
| stop_irq_en | input | 1 | Allow stop conditions to set `stop_flag` |
| flag_clr | input | 3 | Write-one-to-clear strobes: bit 0 amatch, bit 1 drdy, bit 2 stop |
| nack_cmd | input | 1 | Acknowledge choice sampled at a flag clear: 0 ACK, 1 NACK |
| tx_data | input | 8 | Byte to transmit, sampled when `drdy_flag` is cleared in a read |
| rx_data | output | 8 | Last byte received in a master write |
| amatch_flag | output | 1 | Address matched; clock held low |
| drdy_flag | output | 1 | Byte ready or byte wanted; clock held low |
| stop_flag | output | 1 | Stop seen after being addressed |
| dir | output | 1 | Direction of the last matched address, 1 = master read |
| coll | output | 1 | A transmit collision occurred since the last acknowledged address clear |

## Verification
The bench plays an open-drain master against the block and goes after the cases where a stateful target typically slips. It clocks a matching address with no start, which a design that listens all the time would acknowledge. It sends a mismatching read address, which a careless design would use to flip `dir`. It lets the master release the clock while a flag is pending; a design that stretches only for a fixed time would free the bus there. Other runs cover a host NACK followed by further bytes, a repeated start that changes direction, a master NACK at the end of a read, and a stop with the enable off or after an unaddressed transfer. In a forced collision, a wrong design would keep driving or raise a flag instead of setting `coll` silently and clearing it only at the next address clear.

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  input  logic [DW-2:0] own_addr,
  input  logic          stop_irq_en,
  input  logic [2:0]    flag_clr,
  input  logic          nack_cmd,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_data,
  output logic          amatch_flag,
  output logic          drdy_flag,
  output logic          stop_flag,
  output logic          dir,
  output logic          coll
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AHOLD, S_ACK, S_RX, S_RHOLD, S_THOLD, S_TX, S_MACK, S_DONE
  } state_t;

  state_t        st;
  logic [2:0]    scl_p, sda_p;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg, txsh;
  logic          nack_l, mack;

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start_c  = scl_p[1] & scl_p[2] & ~sda_p[1] & sda_p[2];
  wire stop_c   = scl_p[1] & scl_p[2] & sda_p[1] & ~sda_p[2];

  assign scl_drive_low = (st == S_AHOLD) || (st == S_RHOLD) || (st == S_THOLD);
  assign sda_drive_low = ((st == S_ACK) && !nack_l) || ((st == S_TX) && !txsh[DW-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      txsh        <= '1;
      rx_data     <= '0;
      nack_l      <= 1'b1;
      mack        <= 1'b0;
      amatch_flag <= 1'b0;
      drdy_flag   <= 1'b0;
      stop_flag   <= 1'b0;
      dir         <= 1'b0;
      coll        <= 1'b0;
    end else begin
      amatch_flag <= amatch_flag & ~flag_clr[0];
      drdy_flag   <= drdy_flag & ~flag_clr[1];
      stop_flag   <= stop_flag & ~flag_clr[2];
      if (stop_c) begin
        if (stop_irq_en && st != S_IDLE && st != S_ADDR) stop_flag <= 1'b1;
        st <= S_IDLE;
      end else if (start_c) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[DW-2:0], sda_p[1]};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (st == S_RX) begin
                rx_data   <= shreg;
                drdy_flag <= 1'b1;
                st        <= S_RHOLD;
              end else if (shreg[DW-1:1] == own_addr) begin
                amatch_flag <= 1'b1;
                dir         <= shreg[0];
                st          <= S_AHOLD;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AHOLD: if (flag_clr[0]) begin
            nack_l <= nack_cmd;
            coll   <= 1'b0;
            st     <= S_ACK;
          end
          S_RHOLD: if (flag_clr[1]) begin
            nack_l <= nack_cmd;
            st     <= S_ACK;
          end
          S_ACK: if (scl_fall) begin
            cnt <= '0;
            if (nack_l) st <= S_DONE;
            else if (dir) begin
              drdy_flag <= 1'b1;
              st        <= S_THOLD;
            end else st <= S_RX;
          end
          S_THOLD: if (flag_clr[1]) begin
            txsh <= tx_data;
            cnt  <= '0;
            st   <= S_TX;
          end
          S_TX: begin
            if (scl_rise && txsh[DW-1] && !sda_p[1]) begin
              coll <= 1'b1;
              txsh <= '1;
              st   <= S_IDLE;
            end else if (scl_fall) begin
              txsh <= {txsh[DW-2:0], 1'b1};
              cnt  <= cnt + 1'b1;
              if (cnt == LAST) st <= S_MACK;
            end
          end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_p[1];
            else if (scl_fall) begin
              if (mack) begin
                drdy_flag <= 1'b1;
                st        <= S_THOLD;
              end else st <= S_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    amatch_flag |-> scl_drive_low);
  p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(amatch_flag) |-> $stable(dir));
  p_drdy_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_flag) |-> scl_drive_low);
  p_coll_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll) |-> (!scl_drive_low && !sda_drive_low && !amatch_flag));
  p_stop_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> $past(stop_irq_en));
  p_w1c_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(amatch_flag) |-> $past(flag_clr[0]));
endmodule

// File: tb/i2c_target_stretch_test.sv
`timescale 1ns/1ps
module i2c_target_stretch_test;
  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic stop_irq_en = 1'b1, nack_cmd = 1'b0;
  logic [2:0] flag_clr = '0;
  logic [7:0] tx_data = '0;
  logic scl_drive_low, sda_drive_low;
  logic [7:0] rx_data;
  logic amatch_flag, drdy_flag, stop_flag, dir, coll;
  int checks = 0, errors = 0;
  bit done = 0;

  wire scl_line = !(m_scl_low || scl_drive_low);
  wire sda_line = !(m_sda_low || sda_drive_low);

  always #2.5 clk = ~clk;

  i2c_target_stretch uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .own_addr(OWN), .stop_irq_en(stop_irq_en), .flag_clr(flag_clr),
    .nack_cmd(nack_cmd), .tx_data(tx_data), .rx_data(rx_data),
    .amatch_flag(amatch_flag), .drdy_flag(drdy_flag), .stop_flag(stop_flag),
    .dir(dir), .coll(coll));

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  function automatic logic addr_hits(input logic [7:0] b);
    return b[7:1] == OWN;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    m_sda_low = !b;
    waitc(H);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    waitc(H);
    s = sda_line;
    m_scl_low = 1'b1;
    waitc(H);
  endtask

  task automatic send8(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
  endtask

  task automatic recv8(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; waitc(H);
    m_scl_low = 1'b0; waitc(H);
    m_sda_low = 1'b1; waitc(H);
    m_scl_low = 1'b1; waitc(H);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; waitc(H);
    m_scl_low = 1'b0; waitc(H);
    m_sda_low = 1'b0; waitc(H);
  endtask

  task automatic host_clear(input logic [2:0] bits, input logic nk);
    @(negedge clk);
    flag_clr = bits;
    nack_cmd = nk;
    @(negedge clk);
    flag_clr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [7:0] b, got;
    void'($urandom(32'h5EED_1234));
    waitc(4);
    rst_n = 1'b1;
    waitc(4);
    // R13 reset state
    check("R13 reset flags", {amatch_flag, drdy_flag, stop_flag, coll, dir}, 5'b0);
    check("R13 reset drives", {scl_drive_low, sda_drive_low}, 2'b0);

    // R1: matching byte with no start
    m_scl_low = 1'b1; waitc(H);
    send8(addr_byte(OWN, 1'b0));
    clock_bit(1'b1, s);
    check("R1 no flag without start", amatch_flag, 1'b0);
    check("R1 no ack without start", s, 1'b1);
    m_scl_low = 1'b0; waitc(H);

    // R2 and R5: mismatching read address
    m_start();
    b = addr_byte(OWN ^ 7'h01, 1'b1);
    check("R2 bench address differs", addr_hits(b), 1'b0);
    send8(b);
    check("R2 no flag on mismatch", {amatch_flag, scl_drive_low}, 2'b00);
    clock_bit(1'b1, s);
    check("R2 mismatch not acked", s, 1'b1);
    check("R5 dir kept on mismatch", dir, 1'b0);
    send8(addr_byte(OWN, 1'b0));
    clock_bit(1'b1, s);
    check("R2 later byte ignored", {amatch_flag, drdy_flag, s}, 3'b001);
    m_stop();
    check("R12 no stop flag when not addressed", stop_flag, 1'b0);

    // R3 R4 R5 R6 R7: write transaction with stretch demo
    m_start();
    send8(addr_byte(OWN, 1'b0));
    check("R3 amatch on match", amatch_flag, 1'b1);
    check("R5 dir write", dir, 1'b0);
    m_sda_low = 1'b0; waitc(H);
    m_scl_low = 1'b0; waitc(60);
    check("R4 clock held while flag set", {scl_line, scl_drive_low}, 2'b01);
    host_clear(3'b001, 1'b0);
    check("R13 amatch cleared", amatch_flag, 1'b0);
    clock_bit(1'b1, s);
    check("R6 address acked", s, 1'b0);
    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom);
      send8(b);
      check("R7 drdy set per byte", {drdy_flag, scl_drive_low}, 2'b11);
      check("R7 rx byte", rx_data, b);
      host_clear(3'b010, k == 3);
      clock_bit(1'b1, s);
      check("R6 data ack follows command", s, (k == 3));
    end
    send8(8'h5A);
    clock_bit(1'b1, s);
    check("R6 ignored after nack", {drdy_flag, scl_drive_low, s}, 3'b001);
    m_stop();
    check("R12 stop flag set", stop_flag, 1'b1);
    host_clear(3'b100, 1'b0);
    check("R13 stop flag cleared", stop_flag, 1'b0);

    // R12: stop with enable off
    stop_irq_en = 1'b0;
    m_start();
    send8(addr_byte(OWN, 1'b0));
    host_clear(3'b001, 1'b0);
    clock_bit(1'b1, s);
    m_stop();
    check("R12 stop flag gated by enable", stop_flag, 1'b0);
    stop_irq_en = 1'b1;

    // R11 R8 R9: write then repeated start into a read
    m_start();
    send8(addr_byte(OWN, 1'b0));
    host_clear(3'b001, 1'b0);
    clock_bit(1'b1, s);
    send8(8'hC3);
    host_clear(3'b010, 1'b0);
    clock_bit(1'b1, s);
    m_start();
    send8(addr_byte(OWN, 1'b1));
    check("R11 repeated start readdresses", amatch_flag, 1'b1);
    check("R5 dir read", dir, 1'b1);
    host_clear(3'b001, 1'b0);
    clock_bit(1'b1, s);
    check("R8 drdy after read address", {drdy_flag, scl_drive_low}, 2'b11);
    for (int k = 0; k < 4; k++) begin
      b = (k == 0) ? 8'h81 : 8'($urandom);
      tx_data = b;
      host_clear(3'b010, 1'b0);
      recv8(got);
      check("R8 tx byte msb first", got, b);
      clock_bit(k == 3, s);
      if (k < 3) check("R9 master ack rearms drdy", {drdy_flag, scl_drive_low}, 2'b11);
      else check("R9 master nack ends read", {drdy_flag, scl_drive_low, sda_drive_low}, 3'b000);
    end
    m_stop();
    host_clear(3'b100, 1'b0);

    // R6: host nacks the address
    m_start();
    send8(addr_byte(OWN, 1'b0));
    host_clear(3'b001, 1'b1);
    clock_bit(1'b1, s);
    check("R6 address nacked", s, 1'b1);
    send8(8'h3C);
    check("R6 no drdy after address nack", drdy_flag, 1'b0);
    m_stop();
    host_clear(3'b100, 1'b0);

    // R10: collision
    m_start();
    send8(addr_byte(OWN, 1'b1));
    host_clear(3'b001, 1'b0);
    clock_bit(1'b1, s);
    tx_data = 8'hFF;
    host_clear(3'b010, 1'b0);
    clock_bit(1'b0, s);
    check("R10 coll set", coll, 1'b1);
    check("R10 lines released no flag",
          {scl_drive_low, sda_drive_low, amatch_flag, drdy_flag}, 4'b0);
    m_stop();
    check("R10 no stop flag after collision", stop_flag, 1'b0);
    m_start();
    send8(addr_byte(OWN, 1'b0));
    check("R10 coll visible at next match", {amatch_flag, coll}, 2'b11);
    host_clear(3'b001, 1'b0);
    check("R10 coll cleared with amatch", coll, 1'b0);
    clock_bit(1'b1, s);
    m_stop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule